// File: doc/BRIEF.md
# Address-Window Write Tracer with Elapsed-Cycle Stamps

This block watches a bus and keeps a record of selected write transfers. A transfer is kept only when it is a write and its address falls inside one of two enabled address ranges. Typical ranges are a single task-ID location that the scheduler writes on every context switch, or a small group of marker addresses for each core. Each kept record holds the address, the written value, the index of the matching range and the number of clock cycles since the record before it. From these records a host can later rebuild how long each task ran or how far apart two markers were. Because the address is stored, it also shows which core wrote a marker.

Records wait in a small first-in first-out queue and leave through a valid/ready port. If the elapsed-cycle count reaches its largest value with no kept write, the block adds a record that carries only a timestamp, so the time line stays unbroken. If the queue is full, a new record is dropped and a saturating lost-record counter goes up by one.

Top module: `qwtrace`

## Requirements
- R1: After reset, rec_valid is 0 and lost_count is 0.
- R2: A record is made only in a cycle with bus_valid=1 and bus_write=1 whose address hits an enabled range. Reads and other writes make no record.
- R3: A range holds every address from its lower bound to its upper bound, both bounds included. The addresses one below the lower bound and one above the upper bound are not recorded.
- R4: A range whose enable input is 0 matches no address.
- R5: A write record has rec_tsonly=0 and carries the bus address and data. rec_win is 0 for a hit in range 0 and 1 for a hit in range 1. When an address lies in both ranges, range 0 takes precedence.
- R6: rec_delta is the number of rising clock edges between the edge that stored this record and the edge that stored the previous one. For the first record, it counts from the first rising edge after reset is released.
- R7: Reads, writes outside the ranges and writes to a disabled range do not move the timestamp reference. The next record's delta still counts from the last stored record.
- R8: When the elapsed count reaches 0xFFFF and the current cycle has no qualifying write, the block makes a timestamp-only record: rec_tsonly=1, rec_win=0, address 0, data 0, delta 0xFFFF. That record restarts the reference.
- R9: The queue holds 4 records and delivers them in arrival order. While rec_valid=1 and rec_ready=0, the record and rec_valid are held unchanged.
- R10: When the queue holds 4 records, a new record is dropped and lost_count goes up by exactly 1, saturating at its maximum. A dropped write does not move the timestamp reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win0_en | input | 1 | Range 0 enable |
| win0_lo | input | 32 | Range 0 lower bound (inclusive) |
| win0_hi | input | 32 | Range 0 upper bound (inclusive) |
| win1_en | input | 1 | Range 1 enable |
| win1_lo | input | 32 | Range 1 lower bound (inclusive) |
| win1_hi | input | 32 | Range 1 upper bound (inclusive) |
| bus_valid | input | 1 | Observed bus transfer is present |
| bus_write | input | 1 | Observed transfer is a write |
| bus_addr | input | 32 | Observed transfer address |
| bus_data | input | 32 | Observed write data |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_tsonly | output | 1 | Record is a timestamp-only record |
| rec_win | output | 1 | Index of the matching range |
| rec_delta | output | 16 | Cycles since the previous stored record |
| rec_addr | output | 32 | Recorded write address |
| rec_data | output | 32 | Recorded write data |
| lost_count | output | 8 | Saturating count of dropped records |

## Verification
The filter is driven with writes spaced by idle cycles in both ranges, then with reads and out-of-range writes placed in range, and with probes at each bound and one address past it. The delta of the following record shows whether ignored traffic moved the reference. A disabled range and overlapping ranges check the enable and the precedence rule. A burst of six writes against a stalled consumer checks order, hold and the drop count. It also confirms that dropped writes leave the reference alone. A long idle stretch must yield a timestamp-only record exactly 0xFFFF cycles after the last stored one, and the next write must be timed from that record.

// File: rtl/qwtrace.sv
module qwtrace #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TSW   = 16,
  parameter int DEPTH = 4,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win0_en,
  input  logic [AW-1:0] win0_lo,
  input  logic [AW-1:0] win0_hi,
  input  logic          win1_en,
  input  logic [AW-1:0] win1_lo,
  input  logic [AW-1:0] win1_hi,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic          rec_tsonly,
  output logic          rec_win,
  output logic [TSW-1:0] rec_delta,
  output logic [AW-1:0] rec_addr,
  output logic [DW-1:0] rec_data,
  output logic [LW-1:0] lost_count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = 2 + TSW + AW + DW;

  logic [EW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [PW:0]    cnt;
  logic [TSW-1:0] gap;

  wire hit0 = win0_en && bus_addr >= win0_lo && bus_addr <= win0_hi;
  wire hit1 = win1_en && bus_addr >= win1_lo && bus_addr <= win1_hi;
  wire qual = bus_valid && bus_write && (hit0 || hit1);
  wire ovf  = (gap == {TSW{1'b1}}) && !qual;
  wire gen  = qual || ovf;
  wire full = (cnt == (PW+1)'(DEPTH));
  wire push = gen && !full;
  wire pop  = rec_valid && rec_ready;

  wire [EW-1:0] entry = qual ? {1'b0, !hit0, gap, bus_addr, bus_data}
                             : {1'b1, 1'b0, gap, {AW{1'b0}}, {DW{1'b0}}};

  assign rec_valid = (cnt != '0);
  assign {rec_tsonly, rec_win, rec_delta, rec_addr, rec_data} = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    gap <= '0;
    else if (push || ovf)          gap <= TSW'(1);
    else if (gap != {TSW{1'b1}})   gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    lost_count <= '0;
    else if (gen && full && lost_count != '1)      lost_count <= lost_count + 1'b1;
  end
endmodule

module qwtrace_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int TSW = 16,
  parameter int LW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win0_lo_le,
  input logic [AW-1:0] win0_lo,
  input logic [AW-1:0] win0_hi,
  input logic [AW-1:0] win1_lo,
  input logic [AW-1:0] win1_hi,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic          rec_tsonly,
  input logic          rec_win,
  input logic [TSW-1:0] rec_delta,
  input logic [AW-1:0] rec_addr,
  input logic [DW-1:0] rec_data,
  input logic [LW-1:0] lost_count
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable({rec_tsonly, rec_win, rec_delta, rec_addr, rec_data})); // R9
  AST_WRITE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) && !rec_tsonly |-> $past(bus_valid && bus_write)); // R2
  AST_TSONLY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_tsonly |-> rec_delta == {TSW{1'b1}} && rec_addr == '0 && rec_data == '0 && !rec_win); // R8
  AST_WIN0_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_tsonly && !rec_win |-> rec_addr >= win0_lo && rec_addr <= win0_hi); // R3
  AST_WIN1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_tsonly && rec_win |-> rec_addr >= win1_lo && rec_addr <= win1_hi); // R3
  AST_LOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lost_count == $past(lost_count) || lost_count == $past(lost_count) + 1'b1); // R10
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !rec_valid && lost_count == '0); // R1
endmodule

bind qwtrace qwtrace_chk #(.AW(AW), .DW(DW), .TSW(TSW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .win0_lo_le(win0_en), .win0_lo(win0_lo), .win0_hi(win0_hi),
  .win1_lo(win1_lo), .win1_hi(win1_hi), .bus_valid(bus_valid), .bus_write(bus_write),
  .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_tsonly(rec_tsonly), .rec_win(rec_win),
  .rec_delta(rec_delta), .rec_addr(rec_addr), .rec_data(rec_data), .lost_count(lost_count));

// File: tb/qwtrace_tb.sv
module qwtrace_tb;
  localparam int MAXD = 65535;

  logic clk = 0, rst_n = 0;
  logic win0_en = 0, win1_en = 0;
  logic [31:0] win0_lo = 0, win0_hi = 0, win1_lo = 0, win1_hi = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic rec_ready = 0;
  logic rec_valid, rec_tsonly, rec_win;
  logic [15:0] rec_delta;
  logic [31:0] rec_addr, rec_data;
  logic [7:0] lost_count;

  always #2.5 clk = ~clk;

  qwtrace u_dut (
    .clk(clk), .rst_n(rst_n),
    .win0_en(win0_en), .win0_lo(win0_lo), .win0_hi(win0_hi),
    .win1_en(win1_en), .win1_lo(win1_lo), .win1_hi(win1_hi),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_data(bus_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_tsonly(rec_tsonly), .rec_win(rec_win),
    .rec_delta(rec_delta), .rec_addr(rec_addr), .rec_data(rec_data), .lost_count(lost_count));

  int checks = 0, errors = 0;
  int cyc = 0, last_ref = 1, exp_lost = 0;
  logic [81:0] q [64];
  int qh = 0, qt = 0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic check(input bit ok, input string req, input logic [81:0] act, input logic [81:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int model_win(input logic [31:0] a);
    if (win0_en && a >= win0_lo && a <= win0_hi) return 0;
    if (win1_en && a >= win1_lo && a <= win1_hi) return 1;
    return -1;
  endfunction

  task automatic bus_op(input logic w, input logic [31:0] a, input logic [31:0] d);
    int e, wi;
    bus_valid = 1; bus_write = w; bus_addr = a; bus_data = d;
    e = cyc + 1;
    wi = model_win(a);
    if (w && wi >= 0) begin
      if (qt - qh < 4) begin
        q[qt % 64] = {1'b0, wi[0], 16'(e - last_ref), a, d};
        qt++;
        last_ref = e;
      end else exp_lost++;
    end
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    rec_ready = 1;
    while (qh != qt && guard < 50) begin
      if (rec_valid) begin
        check({rec_tsonly, rec_win, rec_delta, rec_addr, rec_data} == q[qh % 64], req,
              {rec_tsonly, rec_win, rec_delta, rec_addr, rec_data}, q[qh % 64]);
        qh++;
      end
      guard++;
      @(negedge clk);
    end
    check(!rec_valid, req, 82'(rec_valid), 82'd0);
    rec_ready = 0;
  endtask

  task automatic t_reset();
    check(!rec_valid, "R1", 82'(rec_valid), 82'd0);
    check(lost_count == 0, "R1", 82'(lost_count), 82'd0);
  endtask

  task automatic t_basic();
    repeat (3) @(negedge clk);
    bus_op(1, 32'h104, 32'hA0A0_0001);
    repeat (3) @(negedge clk);
    bus_op(1, 32'h208, 32'hB0B0_0002);
    bus_op(1, 32'h20F, 32'hB0B0_0003);
    drain("R5 R6");
  endtask

  task automatic t_filter();
    bus_op(0, 32'h104, 32'h1111_1111);
    bus_op(1, 32'h300, 32'h2222_2222);
    bus_op(0, 32'h20A, 32'h3333_3333);
    repeat (2) @(negedge clk);
    bus_op(1, 32'h10C, 32'h4444_4444);
    drain("R2 R7");
  endtask

  task automatic t_bounds();
    bus_op(1, 32'h0FF, 32'h5);
    bus_op(1, 32'h100, 32'h6);
    bus_op(1, 32'h10F, 32'h7);
    bus_op(1, 32'h110, 32'h8);
    bus_op(1, 32'h1FF, 32'h9);
    bus_op(1, 32'h200, 32'hA);
    drain("R3");
  endtask

  task automatic t_enable();
    win1_en = 0;
    bus_op(1, 32'h200, 32'hDEAD);
    bus_op(1, 32'h101, 32'hBEEF);
    win1_en = 1;
    drain("R4");
  endtask

  task automatic t_overlap();
    win1_lo = 32'h108;
    bus_op(1, 32'h10A, 32'hC1);
    bus_op(1, 32'h150, 32'hC2);
    drain("R5");
  endtask

  task automatic t_full();
    for (int i = 0; i < 6; i++) bus_op(1, 32'h100 + i, 32'hF000 + i);
    check(rec_valid && rec_addr == 32'h100, "R9", {50'd0, rec_addr}, 82'h100);
    repeat (3) @(negedge clk);
    check(rec_valid && rec_addr == 32'h100 && rec_data == 32'hF000, "R9", {50'd0, rec_data}, 82'hF000);
    check(lost_count == 8'(exp_lost), "R10", 82'(lost_count), 82'(exp_lost));
    drain("R9 R10");
    bus_op(1, 32'h10E, 32'h77);
    drain("R10");
  endtask

  task automatic t_overflow();
    int e_ovf;
    e_ovf = last_ref + MAXD;
    while (cyc < e_ovf) @(negedge clk);
    check(rec_valid && {rec_tsonly, rec_win, rec_delta, rec_addr, rec_data} == {1'b1, 1'b0, 16'hFFFF, 64'd0},
          "R8", {rec_tsonly, rec_win, rec_delta, rec_addr, rec_data}, {1'b1, 1'b0, 16'hFFFF, 64'd0});
    last_ref = e_ovf;
    rec_ready = 1;
    @(negedge clk);
    rec_ready = 0;
    check(!rec_valid, "R8", 82'(rec_valid), 82'd0);
    repeat (4) @(negedge clk);
    bus_op(1, 32'h20C, 32'h99);
    drain("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    win0_en = 1; win0_lo = 32'h100; win0_hi = 32'h10F;
    win1_en = 1; win1_lo = 32'h200; win1_hi = 32'h20F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_filter();
    t_bounds();
    t_enable();
    t_overlap();
    t_full();
    t_overflow();
    finish_run();
  end
endmodule